// File: doc/BRIEF.md
# Local Bus Chip-Select Region Decoder

This block sits on one chip-select window of a processor's local bus that two processors share. Each access carries an 18-bit byte address, a width (byte or 16-bit word), a direction and a one-bit processor id. The decoder picks one target for the access: a system register file, a video processor register port, a 256-entry palette RAM, or a boot ROM. Each processor sees its own boot ROM. The register file and the video processor are outside the block. They are reached through plain request ports, and each answers with read data in the same cycle. The palette RAM and both boot ROMs are modelled inside the block.

The block returns read data one cycle after the request. It is steered into the correct byte lane for byte accesses. The block also reports accesses that match no target, marks writes to the register file as possible interrupt sources, and keeps a sticky flag that records any change to the palette.

A small response state machine orders the result cycle. It has three states:

- `S_IDLE`: no result is presented.
- `S_READ_RSP`: read data is valid.
- `S_WRITE_RSP`: the outcome of a write is reported.

The state machine has three named transitions, which are taken from any state:

- `rd_accept`: a read request is seen, and the next state is `S_READ_RSP`.
- `wr_accept`: a write request is seen, and the next state is `S_WRITE_RSP`.
- `drain`: no request is seen, and the next state is `S_IDLE`.

When two compares match the same address, the fixed order is register file, then video port, then boot ROM, then palette.

Top module: `lbus_region_dec`

## Requirements
- R1: An access whose address satisfies `(addr & 0x3FF00) == 0x04000` goes to the register port. In the request cycle `sreg_req` is high and carries:
  - the write flag,
  - the width,
  - the processor id,
  - `addr[7:0]`,
  - the write data.
  
  In that cycle `vdp_req` stays low.
- R2: An access whose address satisfies `(addr & 0x3FF00) == 0x04100` goes to the video port. In the request cycle `vdp_req` is high with `addr[7:0]`, the write flag, the width and the write data, and `sreg_req` stays low.
- R3: An access whose address satisfies `(addr & 0x3FE00) == 0x04200` uses the palette, which holds 256 16-bit entries indexed by `addr[8:1]`. A 16-bit write stores the word, and later reads return it. Neither external port is strobed for a palette access.
- R4: A read with `addr < 0x400` returns a word from the boot ROM of the requesting processor. Processor id 0 reads the master ROM and id 1 reads the slave ROM.
  - The word index is w = `addr[9:1]`, with h = w[8].
  - The master word is {w[7:0]^h^0x3C, ~w[7:0]}.
  - The slave word is {w[7:0]^h^0xC3, w[7:0]+0x11}.
  - A write to the ROM range is unmapped.
- R5: A byte read returns the addressed byte in `rd_data[7:0]`, with `rd_data[15:8]` zero. An odd address selects the low byte of the target's word, and an even address selects the high byte.
- R6: An access that matches no target raises `acc_unmapped` in the cycle after the request. A read that matches no target returns zero data.
- R7: A 16-bit palette write sets `pal_dirty` from the next cycle on, and it stays set until `pal_dirty_clr` is sampled high. A byte write to the palette range is unmapped and leaves the palette and `pal_dirty` unchanged.
- R8: `wr_irq_hint` is high in the cycle after a write to the register port. It stays low after writes to any other target and after all reads.
- R9: `rd_valid` is high exactly in the cycle after each accepted read, including back-to-back reads. It is never high after a write or an idle cycle.
- R10: After reset, `rd_valid`, `acc_unmapped`, `wr_irq_hint` and `pal_dirty` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access, 0 = byte |
| req_cpu | input | 1 | Requesting processor id |
| req_addr | input | 18 | Byte address within the region |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| pal_dirty_clr | input | 1 | Clears the palette-changed flag |
| sreg_rdata | input | 16 | Register port read data, same cycle |
| vdp_rdata | input | 16 | Video port read data, same cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data, lane-steered |
| acc_unmapped | output | 1 | Previous access matched no target |
| wr_irq_hint | output | 1 | Previous write may raise an interrupt |
| pal_dirty | output | 1 | Palette changed since last clear |
| sreg_req | output | 1 | Register port strobe |
| sreg_we | output | 1 | Register port write |
| sreg_wide | output | 1 | Register port access width |
| sreg_cpu | output | 1 | Register port processor id |
| sreg_addr | output | 8 | Register port offset |
| sreg_wdata | output | 16 | Register port write data |
| vdp_req | output | 1 | Video port strobe |
| vdp_we | output | 1 | Video port write |
| vdp_wide | output | 1 | Video port access width |
| vdp_addr | output | 8 | Video port offset |
| vdp_wdata | output | 16 | Video port write data |

## Verification
The port strobes are combinational, so the bench checks them 1 ns after driving a request at the falling edge, inside the request cycle. Every other result is registered once:

- `rd_valid` and `rd_data`,
- `acc_unmapped`,
- `wr_irq_hint`,
- `pal_dirty`.

These are due in the cycle after the request, so the bench samples them at the next falling edge. It drives the request low at that same edge. Back-to-back reads are sampled at two falling edges in a row, and a further edge confirms that `rd_valid` has dropped.

// File: rtl/lbus_dec_pkg.sv
package lbus_dec_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_SREG,
        TGT_VDP,
        TGT_ROM,
        TGT_PAL
    } tgt_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ_RSP,
        S_WRITE_RSP
    } rsp_state_e;

    // Boot ROM content, computed from the word index and the bank number
    function automatic logic [WORD_W-1:0] rom_word(input logic bank, input logic [15:0] wx);
        logic [7:0] lo;
        logic [7:0] hi;
        lo = wx[7:0];
        hi = wx[15:8];
        if (bank)
            return {lo ^ hi ^ 8'hC3, lo + 8'h11};
        else
            return {lo ^ hi ^ 8'h3C, ~lo};
    endfunction

    // Byte lane steering: odd byte address -> low byte, even -> high byte
    function automatic logic [WORD_W-1:0] lane_pick(input logic wide, input logic a0,
                                                    input logic [WORD_W-1:0] word);
        if (wide)
            return word;
        else if (a0)
            return {{BYTE_W{1'b0}}, word[BYTE_W-1:0]};
        else
            return {{BYTE_W{1'b0}}, word[WORD_W-1:BYTE_W]};
    endfunction

endpackage

// File: rtl/lbus_tgt_decode.sv
module lbus_tgt_decode
    import lbus_dec_pkg::*;
#(
    parameter int          AW        = 18,
    parameter int          ROM_BYTES = 1024,
    parameter logic [17:0] REG_MASK  = 18'h3FF00,
    parameter logic [17:0] SREG_BASE = 18'h04000,
    parameter logic [17:0] VDP_BASE  = 18'h04100,
    parameter logic [17:0] PAL_MASK  = 18'h3FE00,
    parameter logic [17:0] PAL_BASE  = 18'h04200
) (
    input  logic [AW-1:0] addr,
    input  logic          write,
    input  logic          wide,
    output tgt_e          tgt
);

    logic hit_sreg, hit_vdp, hit_rom, hit_pal;

    always_comb begin
        hit_sreg = (addr & AW'(REG_MASK)) == AW'(SREG_BASE);
        hit_vdp  = (addr & AW'(REG_MASK)) == AW'(VDP_BASE);
        hit_rom  = addr < AW'(ROM_BYTES);
        hit_pal  = (addr & AW'(PAL_MASK)) == AW'(PAL_BASE);
    end

    // Fixed order: register file, video port, boot ROM, palette
    always_comb begin
        tgt = TGT_NONE;
        if (hit_sreg)
            tgt = TGT_SREG;
        else if (hit_vdp)
            tgt = TGT_VDP;
        else if (hit_rom)
            tgt = write ? TGT_NONE : TGT_ROM;
        else if (hit_pal)
            tgt = (write && !wide) ? TGT_NONE : TGT_PAL;
    end

endmodule

// File: rtl/lbus_pal_ram.sv
module lbus_pal_ram #(
    parameter int ENTRIES = 256,
    parameter int DW      = 16,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/lbus_boot_rom.sv
module lbus_boot_rom
    import lbus_dec_pkg::*;
#(
    parameter int  ROM_BYTES = 1024,
    localparam int WIW       = $clog2(ROM_BYTES) - 1,
    localparam int BANKS     = 2
) (
    input  logic              cpu,
    input  logic [WIW-1:0]    widx,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] bank_word [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign bank_word[b] = rom_word(1'(b), 16'(widx));
    end

    assign word = bank_word[cpu];

endmodule

// File: rtl/lbus_region_dec.sv
module lbus_region_dec
    import lbus_dec_pkg::*;
#(
    parameter int  AW          = 18,
    parameter int  ROM_BYTES   = 1024,
    parameter int  PAL_ENTRIES = 256,
    localparam int PORT_AW     = 8,
    localparam int PAL_IW      = $clog2(PAL_ENTRIES),
    localparam int ROM_WIW     = $clog2(ROM_BYTES) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_wide,
    input  logic               req_cpu,
    input  logic [AW-1:0]      req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    input  logic               pal_dirty_clr,
    input  logic [WORD_W-1:0]  sreg_rdata,
    input  logic [WORD_W-1:0]  vdp_rdata,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_data,
    output logic               acc_unmapped,
    output logic               wr_irq_hint,
    output logic               pal_dirty,
    output logic               sreg_req,
    output logic               sreg_we,
    output logic               sreg_wide,
    output logic               sreg_cpu,
    output logic [PORT_AW-1:0] sreg_addr,
    output logic [WORD_W-1:0]  sreg_wdata,
    output logic               vdp_req,
    output logic               vdp_we,
    output logic               vdp_wide,
    output logic [PORT_AW-1:0] vdp_addr,
    output logic [WORD_W-1:0]  vdp_wdata
);

    tgt_e              tgt;
    rsp_state_e        state_q, state_d;
    logic [WORD_W-1:0] pal_word, rom_out, raw_word;
    logic [WORD_W-1:0] rdata_q;
    logic              miss_q, irq_q, dirty_q;
    logic              pal_we;

    lbus_tgt_decode #(
        .AW        (AW),
        .ROM_BYTES (ROM_BYTES)
    ) u_decode (
        .addr  (req_addr),
        .write (req_write),
        .wide  (req_wide),
        .tgt   (tgt)
    );

    assign pal_we = req_valid && req_write && (tgt == TGT_PAL);

    lbus_pal_ram #(
        .ENTRIES (PAL_ENTRIES),
        .DW      (WORD_W)
    ) u_pal (
        .clk   (clk),
        .we    (pal_we),
        .idx   (req_addr[PAL_IW:1]),
        .wdata (req_wdata),
        .rdata (pal_word)
    );

    lbus_boot_rom #(
        .ROM_BYTES (ROM_BYTES)
    ) u_rom (
        .cpu  (req_cpu),
        .widx (req_addr[ROM_WIW:1]),
        .word (rom_out)
    );

    // External port strobes, valid in the request cycle
    always_comb begin
        sreg_req   = req_valid && (tgt == TGT_SREG);
        sreg_we    = req_write;
        sreg_wide  = req_wide;
        sreg_cpu   = req_cpu;
        sreg_addr  = req_addr[PORT_AW-1:0];
        sreg_wdata = req_wdata;
        vdp_req    = req_valid && (tgt == TGT_VDP);
        vdp_we     = req_write;
        vdp_wide   = req_wide;
        vdp_addr   = req_addr[PORT_AW-1:0];
        vdp_wdata  = req_wdata;
    end

    always_comb begin
        unique case (tgt)
            TGT_SREG: raw_word = sreg_rdata;
            TGT_VDP:  raw_word = vdp_rdata;
            TGT_ROM:  raw_word = rom_out;
            TGT_PAL:  raw_word = pal_word;
            default:  raw_word = '0;
        endcase
    end

    // Next-state: rd_accept, wr_accept, drain
    always_comb begin
        unique case (state_q)
            S_IDLE, S_READ_RSP, S_WRITE_RSP: begin
                if (req_valid)
                    state_d = req_write ? S_WRITE_RSP : S_READ_RSP;
                else
                    state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            miss_q  <= 1'b0;
            irq_q   <= 1'b0;
            dirty_q <= 1'b0;
        end else begin
            if (req_valid) begin
                rdata_q <= lane_pick(req_wide, req_addr[0], raw_word);
                miss_q  <= (tgt == TGT_NONE);
                irq_q   <= req_write && (tgt == TGT_SREG);
            end
            if (pal_we)
                dirty_q <= 1'b1;
            else if (pal_dirty_clr)
                dirty_q <= 1'b0;
        end
    end

    // Outputs per state
    always_comb begin
        rd_valid     = 1'b0;
        rd_data      = '0;
        acc_unmapped = 1'b0;
        wr_irq_hint  = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_READ_RSP: begin
                rd_valid     = 1'b1;
                rd_data      = rdata_q;
                acc_unmapped = miss_q;
            end
            S_WRITE_RSP: begin
                acc_unmapped = miss_q;
                wr_irq_hint  = irq_q;
            end
            default: ;
        endcase
    end

    assign pal_dirty = dirty_q;

endmodule

// File: rtl/lbus_region_dec_chk.sv
module lbus_region_dec_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic          req_wide,
    input logic [AW-1:0] req_addr,
    input logic          rd_valid,
    input logic [15:0]   rd_data,
    input logic          acc_unmapped,
    input logic          wr_irq_hint,
    input logic          pal_dirty,
    input logic          sreg_req,
    input logic [7:0]    sreg_addr,
    input logic          vdp_req
);

    logic sreg_hit, pal_hit;
    assign sreg_hit = (req_addr & AW'(18'h3FF00)) == AW'(18'h04000);
    assign pal_hit  = (req_addr & AW'(18'h3FE00)) == AW'(18'h04200);

    a_r9_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rd_valid);

    a_r9_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    a_r6_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && acc_unmapped |-> rd_data == 16'h0000);

    a_r5_byte_high_clear: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && !req_wide |=> rd_data[15:8] == 8'h00);

    a_r1_sreg_forward: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && sreg_hit |-> sreg_req && !vdp_req && sreg_addr == req_addr[7:0]);

    a_r8_hint_source: assert property (@(posedge clk) disable iff (!rst_n)
        wr_irq_hint |-> $past(req_valid && req_write && sreg_hit));

    a_r7_dirty_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pal_dirty) |-> $past(req_valid && req_write && req_wide && pal_hit));

endmodule

bind lbus_region_dec lbus_region_dec_chk #(.AW(AW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_wide     (req_wide),
    .req_addr     (req_addr),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .acc_unmapped (acc_unmapped),
    .wr_irq_hint  (wr_irq_hint),
    .pal_dirty    (pal_dirty),
    .sreg_req     (sreg_req),
    .sreg_addr    (sreg_addr),
    .vdp_req      (vdp_req)
);

// File: tb/lbus_region_dec_tb.sv
module lbus_region_dec_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;
    localparam int NVEC       = 28;

    // {wr, wide, cpu, addr[17:0], wdata[15:0], exp_data[15:0], exp_unmapped, exp_irq}
    localparam logic [54:0] VEC [NVEC] = '{
        {1'b0,1'b1,1'b0,18'h04006,16'h0000,16'hE006,1'b0,1'b0},  // R1 wide
        {1'b0,1'b0,1'b1,18'h04007,16'h0000,16'h0007,1'b0,1'b0},  // R1/R5 odd byte
        {1'b0,1'b0,1'b1,18'h04006,16'h0000,16'h00E1,1'b0,1'b0},  // R1/R5 even byte
        {1'b0,1'b1,1'b0,18'h04108,16'h0000,16'h7D08,1'b0,1'b0},  // R2
        {1'b0,1'b0,1'b0,18'h04109,16'h0000,16'h0009,1'b0,1'b0},  // R2/R5
        {1'b0,1'b1,1'b0,18'h00004,16'h0000,16'h3EFD,1'b0,1'b0},  // R4 master
        {1'b0,1'b1,1'b1,18'h00004,16'h0000,16'hC113,1'b0,1'b0},  // R4 slave
        {1'b0,1'b0,1'b0,18'h00005,16'h0000,16'h00FD,1'b0,1'b0},  // R4/R5
        {1'b0,1'b0,1'b1,18'h00004,16'h0000,16'h00C1,1'b0,1'b0},  // R4/R5
        {1'b0,1'b1,1'b0,18'h003FE,16'h0000,16'hC200,1'b0,1'b0},  // R4 last word
        {1'b0,1'b1,1'b0,18'h00400,16'h0000,16'h0000,1'b1,1'b0},  // R6 past ROM
        {1'b0,1'b1,1'b1,18'h24000,16'h0000,16'h0000,1'b1,1'b0},  // R6
        {1'b1,1'b1,1'b0,18'h04210,16'h1234,16'h0000,1'b0,1'b0},  // R3 write
        {1'b0,1'b1,1'b0,18'h04210,16'h0000,16'h1234,1'b0,1'b0},  // R3
        {1'b0,1'b0,1'b0,18'h04211,16'h0000,16'h0034,1'b0,1'b0},  // R3/R5
        {1'b0,1'b0,1'b0,18'h04210,16'h0000,16'h0012,1'b0,1'b0},  // R3/R5
        {1'b1,1'b1,1'b0,18'h04212,16'h5678,16'h0000,1'b0,1'b0},  // R3
        {1'b1,1'b0,1'b0,18'h04213,16'h00FF,16'h0000,1'b1,1'b0},  // R7 byte write
        {1'b0,1'b1,1'b0,18'h04212,16'h0000,16'h5678,1'b0,1'b0},  // R7 unchanged
        {1'b1,1'b1,1'b1,18'h043FE,16'hBEEF,16'h0000,1'b0,1'b0},  // R3 top entry
        {1'b1,1'b1,1'b0,18'h04200,16'h0001,16'h0000,1'b0,1'b0},  // R3 entry 0
        {1'b0,1'b1,1'b0,18'h043FE,16'h0000,16'hBEEF,1'b0,1'b0},  // R3
        {1'b0,1'b1,1'b1,18'h04200,16'h0000,16'h0001,1'b0,1'b0},  // R3
        {1'b1,1'b1,1'b0,18'h04004,16'hAAAA,16'h0000,1'b0,1'b1},  // R8
        {1'b1,1'b0,1'b1,18'h04005,16'h0055,16'h0000,1'b0,1'b1},  // R8 byte
        {1'b1,1'b1,1'b0,18'h04100,16'h1111,16'h0000,1'b0,1'b0},  // R8 video: none
        {1'b1,1'b1,1'b0,18'h00010,16'h2222,16'h0000,1'b1,1'b0},  // R4 ROM write
        {1'b0,1'b1,1'b0,18'h04400,16'h0000,16'h0000,1'b1,1'b0}   // R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0, req_cpu = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        pal_dirty_clr = 1'b0;
    logic [15:0] sreg_rdata, vdp_rdata;
    logic        rd_valid, acc_unmapped, wr_irq_hint, pal_dirty;
    logic [15:0] rd_data;
    logic        sreg_req, sreg_we, sreg_wide, sreg_cpu;
    logic [7:0]  sreg_addr, vdp_addr;
    logic [15:0] sreg_wdata, vdp_wdata;
    logic        vdp_req, vdp_we, vdp_wide;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Responders: same-cycle read data derived from the port offset
    assign sreg_rdata = {sreg_cpu ? 8'hE1 : 8'hE0, sreg_addr};
    assign vdp_rdata  = {8'h7D, vdp_addr};

    lbus_region_dec dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_cpu(req_cpu), .req_addr(req_addr),
        .req_wdata(req_wdata), .pal_dirty_clr(pal_dirty_clr),
        .sreg_rdata(sreg_rdata), .vdp_rdata(vdp_rdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .acc_unmapped(acc_unmapped), .wr_irq_hint(wr_irq_hint),
        .pal_dirty(pal_dirty), .sreg_req(sreg_req), .sreg_we(sreg_we),
        .sreg_wide(sreg_wide), .sreg_cpu(sreg_cpu), .sreg_addr(sreg_addr),
        .sreg_wdata(sreg_wdata), .vdp_req(vdp_req), .vdp_we(vdp_we),
        .vdp_wide(vdp_wide), .vdp_addr(vdp_addr), .vdp_wdata(vdp_wdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic wide, input logic cpu,
                         input logic [17:0] addr, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wide = wide;
        req_cpu = cpu; req_addr = addr; req_wdata = wd;
    endtask

    // One access; returns at the falling edge of the result cycle
    task automatic access(input logic wr, input logic wide, input logic cpu,
                          input logic [17:0] addr, input logic [15:0] wd);
        drive(wr, wide, cpu, addr, wd);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 rd_valid", 16'(rd_valid), 16'h0);
        check("R10 acc_unmapped", 16'(acc_unmapped), 16'h0);
        check("R10 wr_irq_hint", 16'(wr_irq_hint), 16'h0);
        check("R10 pal_dirty", 16'(pal_dirty), 16'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic [54:0] v;
            v = VEC[i];
            access(v[54], v[53], v[52], v[51:34], v[33:18]);
            check($sformatf("vec %0d R9 rd_valid", i), 16'(rd_valid), 16'(!v[54]));
            if (!v[54])
                check($sformatf("vec %0d R1/R2/R3/R4/R5 rd_data", i), rd_data, v[17:2]);
            check($sformatf("vec %0d R6 acc_unmapped", i), 16'(acc_unmapped), 16'(v[1]));
            check($sformatf("vec %0d R8 wr_irq_hint", i), 16'(wr_irq_hint), 16'(v[0]));
        end

        // R1: register port strobes in the request cycle
        drive(1'b1, 1'b0, 1'b1, 18'h04033, 16'h00C5);
        #1;
        check("R1 sreg_req", 16'(sreg_req), 16'h1);
        check("R1 sreg_we", 16'(sreg_we), 16'h1);
        check("R1 sreg_wide", 16'(sreg_wide), 16'h0);
        check("R1 sreg_cpu", 16'(sreg_cpu), 16'h1);
        check("R1 sreg_addr", 16'(sreg_addr), 16'h0033);
        check("R1 sreg_wdata", sreg_wdata, 16'h00C5);
        check("R1 vdp_req low", 16'(vdp_req), 16'h0);
        // R2: video port strobes
        drive(1'b0, 1'b1, 1'b0, 18'h041F0, 16'h0000);
        #1;
        check("R2 vdp_req", 16'(vdp_req), 16'h1);
        check("R2 vdp_we", 16'(vdp_we), 16'h0);
        check("R2 vdp_wide", 16'(vdp_wide), 16'h1);
        check("R2 vdp_addr", 16'(vdp_addr), 16'h00F0);
        check("R2 sreg_req low", 16'(sreg_req), 16'h0);
        // R3: palette access strobes neither port
        drive(1'b0, 1'b1, 1'b0, 18'h04220, 16'h0000);
        #1;
        check("R3 sreg_req low", 16'(sreg_req), 16'h0);
        check("R3 vdp_req low", 16'(vdp_req), 16'h0);
        @(negedge clk);
        req_valid = 1'b0;

        // R9: back-to-back reads
        drive(1'b0, 1'b1, 1'b0, 18'h04002, 16'h0000);
        drive(1'b0, 1'b1, 1'b0, 18'h04104, 16'h0000);
        check("R9 b2b first valid", 16'(rd_valid), 16'h1);
        check("R9 b2b first data", rd_data, 16'hE002);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 b2b second valid", 16'(rd_valid), 16'h1);
        check("R9 b2b second data", rd_data, 16'h7D04);
        @(negedge clk);
        check("R9 idle no valid", 16'(rd_valid), 16'h0);

        // R7: sticky dirty flag
        check("R7 dirty after palette writes", 16'(pal_dirty), 16'h1);
        @(negedge clk);
        pal_dirty_clr = 1'b1;
        @(negedge clk);
        pal_dirty_clr = 1'b0;
        check("R7 dirty cleared", 16'(pal_dirty), 16'h0);
        access(1'b1, 1'b0, 1'b0, 18'h04250, 16'h0077);
        check("R7 byte write no dirty", 16'(pal_dirty), 16'h0);
        check("R7 byte write unmapped", 16'(acc_unmapped), 16'h1);
        access(1'b1, 1'b1, 1'b1, 18'h04250, 16'h0F0F);
        check("R7 word write sets dirty", 16'(pal_dirty), 16'h1);
        repeat (3) @(negedge clk);
        check("R7 dirty holds", 16'(pal_dirty), 16'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule